// File: doc/BRIEF.md
# PLL Control Register Bank with Unlock-Sequence Commit

This block holds the software-visible control and configuration for a clock generator's phase-locked loop. It stores an enable bit, a connect bit, a multiplier field and a pre-divider field. Bus writes to the control and configuration registers only update shadow copies. The settings that actually drive the PLL stay unchanged until software writes a two-value unlock sequence to a separate feed register. At that point every shadow field moves into the active set in one clock edge.

The multiplier and pre-divider are stored as value minus one. The bank applies the connect request without looking at the lock input, and it never drops connect by itself when lock goes away. A read-only status register reports the active settings together with the live lock input, so software can tell what is pending from what is in force.

Top module: `pll_feed_regbank`

## Requirements
- R1: After synchronous reset, pll_enable, pll_connect, pll_mul_m1 and pll_div_n1 are all 0, and the control and configuration registers read back 0.
- R2: Register map by bus_addr: 0 control, 1 configuration, 2 feed, 3 status. A control write stores bit 0 as the pending enable and bit 1 as the pending connect. A control read returns those two bits, and bits 31:2 read 0.
- R3: A configuration write stores bits 14:0 as the pending multiplier-minus-one and bits 23:16 as the pending pre-divider-minus-one. A read returns them in the same positions, and bit 15 and bits 31:24 read 0 whatever was written.
- R4: Control and configuration writes leave pll_enable, pll_connect, pll_mul_m1, pll_div_n1 and the status register unchanged until a valid feed completes.
- R5: A valid feed is a feed-register write with low byte 0xAA followed by a feed-register write with low byte 0x55. Idle cycles may separate the two writes. From the cycle after the second write, all four active outputs equal the pending values.
- R6: Between the two feed writes, a write to any other register, or a feed write whose low byte is neither 0xAA nor 0x55, cancels the sequence and nothing is committed. A repeated 0xAA re-arms the sequence.
- R7: pll_connect is 1 only while pll_enable is 1. Committing connect=1 with enable=0 gives pll_connect=0.
- R8: Connect is committed whatever the state of pll_locked, and a later fall of pll_locked does not change pll_connect.
- R9: The status register reads active multiplier-minus-one in bits 14:0, active pre-divider-minus-one in bits 23:16, active enable in bit 24, active connect in bit 25 and pll_locked in bit 26. All other bits read 0.
- R10: The feed register reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 2 | Register select for write and read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pll_locked | input | 1 | Lock indication from the PLL |
| pll_enable | output | 1 | Active PLL enable |
| pll_connect | output | 1 | Active clock-source connect |
| pll_mul_m1 | output | 15 | Active multiplier minus one |
| pll_div_n1 | output | 8 | Active pre-divider minus one |

## Verification
A wrong unlock state shows up at the ports one cycle after the second feed write. The active outputs then either move when they should not, or stay put when they should change. A corrupted shadow field is visible at once on the next register read, and again in the active outputs after the next commit. A missing connect gate or a stray lock dependency shows on pll_connect in the first cycle after a commit, or in the first cycle after pll_locked falls.

// File: rtl/pllreg_pkg.sv
package pllreg_pkg;

    localparam int DATA_W   = 32;
    localparam int M_W      = 15;
    localparam int N_W      = 8;
    localparam int N_LSB    = 16;
    localparam int ST_EN    = 24;
    localparam int ST_CONN  = 25;
    localparam int ST_LOCK  = 26;
    localparam int KEY_W    = 8;

    localparam logic [KEY_W-1:0] KEY_FIRST  = 8'hAA;
    localparam logic [KEY_W-1:0] KEY_SECOND = 8'h55;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_CFG  = 2'd1,
        SEL_FEED = 2'd2,
        SEL_STAT = 2'd3
    } reg_sel_e;

    typedef enum logic {
        UNLK_IDLE  = 1'b0,
        UNLK_ARMED = 1'b1
    } unlock_st_e;

    typedef struct packed {
        logic           en;
        logic           conn;
        logic [M_W-1:0] m1;
        logic [N_W-1:0] n1;
    } pll_set_t;

    function automatic logic [DATA_W-1:0] ctrl_word(pll_set_t s);
        logic [DATA_W-1:0] w;
        w    = '0;
        w[0] = s.en;
        w[1] = s.conn;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] cfg_word(pll_set_t s);
        logic [DATA_W-1:0] w;
        w              = '0;
        w[M_W-1:0]     = s.m1;
        w[N_LSB+:N_W]  = s.n1;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] stat_word(pll_set_t s, logic lock);
        logic [DATA_W-1:0] w;
        w          = cfg_word(s);
        w[ST_EN]   = s.en;
        w[ST_CONN] = s.conn;
        w[ST_LOCK] = lock;
        return w;
    endfunction

endpackage

// File: rtl/pllreg_shadow.sv
module pllreg_shadow
    import pllreg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  reg_sel_e            wr_sel,
    input  logic [1:0]          ctrl_bits,
    input  logic [M_W-1:0]      m_field,
    input  logic [N_W-1:0]      n_field,
    output pll_set_t            pending
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_CTRL: begin
                    pending.en   <= ctrl_bits[0];
                    pending.conn <= ctrl_bits[1];
                end
                SEL_CFG: begin
                    pending.m1 <= m_field;
                    pending.n1 <= n_field;
                end
                default: ;
            endcase
        end
    end

    // R2: control write lands in the pending enable/connect
    a_r2_ctrl_capture: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_CTRL) |=>
            (pending.en == $past(ctrl_bits[0]) && pending.conn == $past(ctrl_bits[1])));

    // R3: configuration write lands in the pending fields
    a_r3_cfg_capture: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_CFG) |=>
            (pending.m1 == $past(m_field) && pending.n1 == $past(n_field)));

endmodule

// File: rtl/pllreg_unlock.sv
module pllreg_unlock
    import pllreg_pkg::*;
#(
    parameter logic [KEY_W-1:0] FIRST  = KEY_FIRST,
    parameter logic [KEY_W-1:0] SECOND = KEY_SECOND
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  reg_sel_e         wr_sel,
    input  logic [KEY_W-1:0] key,
    output logic             commit
);

    unlock_st_e state, state_nx;
    logic       feed_wr;

    assign feed_wr = wr_en && (wr_sel == SEL_FEED);

    always_comb begin
        state_nx = state;
        commit   = 1'b0;
        if (wr_en) begin
            if (!feed_wr) begin
                state_nx = UNLK_IDLE;
            end else if (key == FIRST) begin
                state_nx = UNLK_ARMED;
            end else if (state == UNLK_ARMED && key == SECOND) begin
                commit   = 1'b1;
                state_nx = UNLK_IDLE;
            end else begin
                state_nx = UNLK_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= UNLK_IDLE;
        else     state <= state_nx;
    end

    // R6: a write elsewhere leaves the sequence unable to complete next cycle
    a_r6_cancel: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel != SEL_FEED) |=> !commit);

    // R5: a commit needs the first key on the last feed write
    a_r5_needs_first: assert property (@(posedge clk) disable iff (rst)
        (feed_wr && key == FIRST) |=> (state == UNLK_ARMED));

endmodule

// File: rtl/pllreg_active.sv
module pllreg_active
    import pllreg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     commit,
    input  pll_set_t pending,
    output pll_set_t active
);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= '0;
        end else if (commit) begin
            active.en   <= pending.en;
            active.conn <= pending.conn & pending.en;
            active.m1   <= pending.m1;
            active.n1   <= pending.n1;
        end
    end

    // R4: nothing moves without a commit
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(active));

    // R5: a commit copies every pending field in one edge
    a_r5_copy: assert property (@(posedge clk) disable iff (rst)
        commit |=> (active.en == $past(pending.en) && active.m1 == $past(pending.m1)
                    && active.n1 == $past(pending.n1)));

    // R7: connect never stands without enable
    a_r7_gate: assert property (@(posedge clk) disable iff (rst)
        active.conn |-> active.en);

endmodule

// File: rtl/pll_feed_regbank.sv
module pll_feed_regbank
    import pllreg_pkg::*;
#(
    parameter logic [KEY_W-1:0] FIRST_KEY  = KEY_FIRST,
    parameter logic [KEY_W-1:0] SECOND_KEY = KEY_SECOND
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              pll_locked,
    output logic              pll_enable,
    output logic              pll_connect,
    output logic [M_W-1:0]    pll_mul_m1,
    output logic [N_W-1:0]    pll_div_n1
);

    reg_sel_e sel;
    pll_set_t pending;
    pll_set_t active;
    logic     commit;
    logic     unused_rsvd;

    assign sel         = reg_sel_e'(bus_addr);
    assign unused_rsvd = ^{bus_wdata[DATA_W-1:N_LSB+N_W], bus_wdata[M_W]};

    pllreg_shadow u_shadow (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (bus_wr),
        .wr_sel    (sel),
        .ctrl_bits (bus_wdata[1:0]),
        .m_field   (bus_wdata[M_W-1:0]),
        .n_field   (bus_wdata[N_LSB+:N_W]),
        .pending   (pending)
    );

    pllreg_unlock #(
        .FIRST  (FIRST_KEY),
        .SECOND (SECOND_KEY)
    ) u_unlock (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (bus_wr),
        .wr_sel (sel),
        .key    (bus_wdata[KEY_W-1:0]),
        .commit (commit)
    );

    pllreg_active u_active (
        .clk     (clk),
        .rst     (rst),
        .commit  (commit),
        .pending (pending),
        .active  (active)
    );

    assign pll_enable  = active.en;
    assign pll_connect = active.conn;
    assign pll_mul_m1  = active.m1;
    assign pll_div_n1  = active.n1;

    always_comb begin
        case (sel)
            SEL_CTRL: bus_rdata = ctrl_word(pending);
            SEL_CFG:  bus_rdata = cfg_word(pending);
            SEL_STAT: bus_rdata = stat_word(active, pll_locked);
            default:  bus_rdata = '0;
        endcase
    end

    // R8: losing lock does not pull connect down
    a_r8_no_auto_drop: assert property (@(posedge clk) disable iff (rst)
        (!commit && $fell(pll_locked)) |=> $stable(pll_connect));

endmodule

// File: tb/tb_pll_feed_regbank.sv
`timescale 1ns/1ps
module tb_pll_feed_regbank;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pll_locked = 1'b0;
    logic        pll_enable, pll_connect;
    logic [14:0] pll_mul_m1;
    logic [7:0]  pll_div_n1;

    always #10 clk = ~clk;

    pll_feed_regbank dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pll_locked(pll_locked),
        .pll_enable(pll_enable), .pll_connect(pll_connect),
        .pll_mul_m1(pll_mul_m1), .pll_div_n1(pll_div_n1)
    );

    typedef struct {
        string       tag;
        logic        en;
        logic        conn;
        logic [14:0] m;
        logic [7:0]  n;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   failures = 0;
    bit   done = 0;

    // reference model of the requirements
    logic        s_en = 0, s_conn = 0, a_en = 0, a_conn = 0, armed = 0;
    logic [14:0] s_m = 0, a_m = 0;
    logic [7:0]  s_n = 0, a_n = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push(string tag);
        exp_t e;
        e.tag = tag; e.en = a_en; e.conn = a_conn; e.m = a_m; e.n = a_n;
        q.push_back(e);
    endtask

    always @(negedge clk) begin
        exp_t e;
        if (q.size() > 0) begin
            e = q.pop_front();
            chk({e.tag, " out"}, {pll_enable, pll_connect, 6'd0, pll_div_n1, 1'b0, pll_mul_m1},
                {e.en, e.conn, 6'd0, e.n, 1'b0, e.m});
        end
    end

    task automatic wr(logic [1:0] a, logic [31:0] d, string tag);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
        if (a == 2'd2) begin
            if (d[7:0] == 8'hAA) armed = 1;
            else begin
                if (armed && d[7:0] == 8'h55) begin
                    a_en = s_en; a_conn = s_conn & s_en; a_m = s_m; a_n = s_n;
                end
                armed = 0;
            end
        end else begin
            armed = 0;
            if (a == 2'd0) begin s_en = d[0]; s_conn = d[1]; end
            if (a == 2'd1) begin s_m = d[14:0]; s_n = d[23:16]; end
        end
        push(tag);
    endtask

    task automatic idle(string tag);
        @(posedge clk); #1;
        push(tag);
    endtask

    task automatic rd(logic [1:0] a, logic [31:0] exp, string tag);
        bus_addr = a; #1;
        chk(tag, bus_rdata, exp);
    endtask

    function automatic logic [31:0] stat_exp();
        return {5'd0, pll_locked, a_conn, a_en, a_n, 1'b0, a_m};
    endfunction

    task automatic feed(string tag);
        wr(2'd2, 32'h0000_00AA, tag);
        wr(2'd2, 32'h0000_0055, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        push("R1");
        rd(2'd0, 32'h0, "R1 ctrl");
        rd(2'd1, 32'h0, "R1 cfg");
        rd(2'd3, 32'h0, "R1 stat");

        // R2/R3: shadow writes, reserved bits dropped
        wr(2'd0, 32'hFFFF_FFFF, "R4");
        rd(2'd0, 32'h0000_0003, "R2 ctrl readback");
        wr(2'd1, 32'hFF01_8018, "R4");
        rd(2'd1, 32'h0001_0018, "R3 cfg readback");
        rd(2'd3, 32'h0, "R4 stat unchanged");

        // R5 + R8: commit with lock low, connect still applied
        feed("R5");
        chk("R5 m", {17'd0, pll_mul_m1}, 32'h18);
        chk("R8 connect without lock", {31'd0, pll_connect}, 32'd1);
        rd(2'd3, 32'h0301_0018, "R9 stat");
        rd(2'd2, 32'h0, "R10 feed read");

        // R6: intervening write cancels
        wr(2'd1, 32'h001F_01FF, "R4");
        wr(2'd2, 32'h0000_00AA, "R6");
        wr(2'd0, 32'h0, "R6");
        wr(2'd2, 32'h0000_0055, "R6 cancelled");
        chk("R6 cancel m", {17'd0, pll_mul_m1}, 32'h18);
        // R5: idle cycles between keys allowed
        wr(2'd2, 32'h0000_00AA, "R5");
        idle("R5"); idle("R5");
        wr(2'd2, 32'h0000_0055, "R5 gap");
        chk("R5 gap m", {17'd0, pll_mul_m1}, 32'h1FF);
        chk("R5 gap en", {31'd0, pll_enable}, 32'd0);

        // R6: wrong key cancels, repeated first key re-arms; R7 gate
        wr(2'd0, 32'h2, "R4");
        wr(2'd2, 32'h0000_00AA, "R6");
        wr(2'd2, 32'h0000_0012, "R6");
        wr(2'd2, 32'h0000_0055, "R6 bad key");
        wr(2'd2, 32'h0000_00AA, "R6");
        wr(2'd2, 32'h0000_00AA, "R6");
        wr(2'd2, 32'h1234_5655, "R6 rearm");
        chk("R7 connect gated", {31'd0, pll_connect}, 32'd0);
        rd(2'd0, 32'h0000_0002, "R2 pending connect");

        // R8: lock fall does not drop connect
        pll_locked = 1'b1;
        wr(2'd0, 32'h3, "R4");
        feed("R8");
        rd(2'd3, stat_exp(), "R9 stat lock");
        pll_locked = 1'b0;
        idle("R8"); idle("R8");
        chk("R8 lock loss", {31'd0, pll_connect}, 32'd1);
        rd(2'd3, 32'h031F_01FF, "R9 stat after lock loss");

        @(posedge clk); #1;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule